// File: doc/BRIEF.md
# Snooping Write-Back Cache Coherence Controller

This block sits between one processor and a shared snooping bus. It holds a small direct-mapped write-back cache of one-word blocks. Each block carries one of three coherence states: Invalid, Shared (a clean read-only copy) or Exclusive (the only copy, writable and dirty). Processor reads and writes that hit complete in the cycle they are presented. A miss stalls the processor, asks for the bus, writes back a dirty victim if there is one, and then issues a read-miss or write-miss transaction. The fill arrives on the bus in the same cycle.

At the same time the block watches every transaction that another cache places on the bus. If a foreign read miss hits an Exclusive line, the block supplies the dirty word, tells memory to abandon its own response, and keeps a Shared copy. If a foreign write miss hits a valid line, the line is dropped. When the foreign write miss hits an Exclusive line, the block also supplies the word and aborts memory first.

Several instances share one bus through an external arbiter and one memory. The memory must take a supplied word both as the fill and as a write-back whenever any cache raises its abort signal.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address goes to the bus.
- R2: A read that finds its line Invalid, or holding another address, places a read miss (command 2'b01) on the bus. The line becomes Shared, holding the word delivered on the bus fill lines, and the read returns that word.
- R3: A write that finds its line not Exclusive for its address places a write miss (command 2'b10). The line becomes Exclusive and the write data is then stored in it.
- R4: A read hit in Shared or Exclusive, and a write hit in Exclusive, raise no bus request, change no state and complete with cpu_ready in the first cycle.
- R5: A miss whose line is Exclusive for another address first issues a write-back (command 2'b11) carrying the victim address and dirty word. The miss transaction follows in the next cycle.
- R6: A foreign read miss that hits an Exclusive line raises snp_abort, drives the dirty word on snp_data and leaves the line Shared, so a later local write needs the bus.
- R7: A foreign write miss that hits a Shared line makes it Invalid.
- R8: A foreign write miss that hits an Exclusive line raises snp_abort, supplies the dirty word and makes the line Invalid.
- R9: The address is split into a low index of IDX_W bits and a high tag. An access whose tag differs from a valid line's tag at the same index is a miss.
- R10: Bus transactions whose requester ID equals the block's own ID (and the idle command 2'b00 or write-back 2'b11) are never snooped.
- R11: cpu_ready stays low while a miss waits for grant, write-back or fill, and also in any cycle in which a snoop hits this cache. The block drives a non-idle command only while granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | Command driven when granted |
| bus_id_o | output | ID_W | Own requester ID |
| bus_addr_o | output | ADDR_W | Transaction address (victim address for write-back) |
| bus_data_o | output | DATA_W | Write-back data |
| bus_cmd_i | input | 2 | Command currently on the shared bus |
| bus_id_i | input | ID_W | Requester ID on the bus |
| bus_addr_i | input | ADDR_W | Address on the bus |
| bus_fill_i | input | DATA_W | Fill word returned for this cycle's miss |
| snp_abort | output | 1 | Snoop hit on a dirty line: memory must not answer |
| snp_data | output | DATA_W | Dirty word supplied with snp_abort |

## Verification
The bench builds two instances with IDX_W=2 and a four-bit address, so there are four lines and four addresses per line. With so few slots, random accesses keep running into conflicting tags, dirty victims and lines that both caches hold. The eight-bit data lets a reference model track every address's latest value. The bench also checks the exact number of bus transactions and aborts for each access. A directed opening runs the classic two-cache write, read, remote read, remote write and conflicting-address walk before the random phase.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_EXC = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WBACK  = 2'b11
  } bus_cmd_e;

  function automatic logic is_valid(line_st_e s);
    return s != LN_INV;
  endfunction

  function automatic logic is_snoopable(bus_cmd_e c);
    return (c == BC_RDMISS) || (c == BC_WRMISS);
  endfunction

  function automatic bus_cmd_e miss_cmd(logic we);
    return we ? BC_WRMISS : BC_RDMISS;
  endfunction
endpackage

// File: rtl/scc_line_store.sv
module scc_line_store
  import scc_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic              fill_we,
  input  line_st_e          fill_st,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              wr_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  s_idx,
  output line_st_e          s_st,
  output logic [TAG_W-1:0]  s_tag,
  output logic [DATA_W-1:0] s_data,
  input  logic              s_we,
  input  line_st_e          s_new
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g] <= LN_INV;
      end else if (s_we && s_idx == IDX_W'(g)) begin
        st_q[g] <= s_new;
      end else if (fill_we && a_idx == IDX_W'(g)) begin
        st_q[g] <= fill_st;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_we && a_idx == IDX_W'(g)) begin
        tag_q[g] <= fill_tag;
        dat_q[g] <= fill_data;
      end else if (wr_we && a_idx == IDX_W'(g)) begin
        dat_q[g] <= wr_data;
      end
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = dat_q[a_idx];
  assign s_st   = st_q[s_idx];
  assign s_tag  = tag_q[s_idx];
  assign s_data = dat_q[s_idx];

  // R11
  fill_snoop_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_we && s_we));

  // R11
  write_not_during_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_we && s_we));
endmodule

// File: rtl/scc_snoop.sv
module scc_snoop
  import scc_pkg::*;
#(
  parameter int              TAG_W  = 5,
  parameter int              DATA_W = 32,
  parameter int              ID_W   = 1,
  parameter logic [ID_W-1:0] MY_ID  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_cmd_e          cmd,
  input  logic [ID_W-1:0]   req_id,
  input  logic [TAG_W-1:0]  req_tag,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              hit,
  output logic              upd_we,
  output line_st_e          upd_st,
  output logic              abort,
  output logic [DATA_W-1:0] sup_data
);
  logic foreign;

  assign foreign  = req_id != MY_ID;
  assign hit      = foreign && is_snoopable(cmd) && is_valid(ln_st) && (ln_tag == req_tag);
  assign abort    = hit && (ln_st == LN_EXC);
  assign upd_st   = (cmd == BC_WRMISS) ? LN_INV : LN_SHR;
  assign upd_we   = hit && ((cmd == BC_WRMISS) || (ln_st == LN_EXC));
  assign sup_data = ln_data;

  // R10
  own_id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_id == MY_ID) |-> !upd_we);

  // R10
  wback_not_snooped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == BC_WBACK || cmd == BC_IDLE) |-> !abort);
endmodule

// File: rtl/scc_ctrl_fsm.sv
module scc_ctrl_fsm
  import scc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpu_req,
  input  logic     cpu_we,
  input  logic     hit,
  input  logic     victim_dirty,
  input  logic     bus_gnt,
  input  logic     snp_busy,
  output logic     cpu_ready,
  output logic     bus_req,
  output bus_cmd_e cmd_o,
  output logic     drive_victim,
  output logic     fill_we,
  output line_st_e fill_st,
  output logic     hit_we
);
  typedef enum logic [1:0] {FS_IDLE, FS_ARB, FS_MISS, FS_DONE} fsm_e;
  fsm_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d    = st_q;
    cmd_o   = BC_IDLE;
    fill_we = 1'b0;
    case (st_q)
      FS_IDLE: if (cpu_req && !hit && !snp_busy) st_d = FS_ARB;
      FS_ARB: begin
        if (bus_gnt) begin
          if (victim_dirty) begin
            cmd_o = BC_WBACK;
            st_d  = FS_MISS;
          end else begin
            cmd_o   = miss_cmd(cpu_we);
            fill_we = 1'b1;
            st_d    = FS_DONE;
          end
        end
      end
      FS_MISS: begin
        if (bus_gnt) begin
          cmd_o   = miss_cmd(cpu_we);
          fill_we = 1'b1;
          st_d    = FS_DONE;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  assign cpu_ready    = (st_q == FS_IDLE) && cpu_req && hit && !snp_busy;
  assign hit_we       = cpu_ready && cpu_we;
  assign bus_req      = (st_q == FS_ARB) || (st_q == FS_MISS);
  assign drive_victim = cmd_o == BC_WBACK;
  assign fill_st      = cpu_we ? LN_EXC : LN_SHR;

  // R11
  drive_only_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != BC_IDLE) |-> bus_gnt);

  // R5
  wback_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == BC_WBACK) |=> (bus_req && !cpu_ready));

  // R11
  miss_asks_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_IDLE && cpu_req && !hit && !snp_busy) |=> (bus_req && !cpu_ready));
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import scc_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter int              IDX_W  = 3,
  parameter int              DATA_W = 32,
  parameter int              ID_W   = 1,
  parameter logic [ID_W-1:0] MY_ID  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd_o,
  output logic [ID_W-1:0]   bus_id_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [1:0]        bus_cmd_i,
  input  logic [ID_W-1:0]   bus_id_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_fill_i,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  line_st_e          a_st, s_st, fill_st, s_new;
  logic [TAG_W-1:0]  a_tag, s_tag;
  logic [DATA_W-1:0] a_data, s_data;
  logic              fill_we, hit_we, s_we, snp_hit, drive_victim;
  logic              tag_eq, cpu_hit, victim_dirty;
  bus_cmd_e          cmd_int, snp_cmd;

  assign snp_cmd      = bus_cmd_e'(bus_cmd_i);
  assign tag_eq       = a_tag == tag_of(cpu_addr);
  assign cpu_hit      = is_valid(a_st) && tag_eq && (!cpu_we || a_st == LN_EXC);
  assign victim_dirty = (a_st == LN_EXC) && !tag_eq;

  scc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .a_idx(idx_of(cpu_addr)), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .fill_we(fill_we), .fill_st(fill_st), .fill_tag(tag_of(cpu_addr)), .fill_data(bus_fill_i),
    .wr_we(hit_we), .wr_data(cpu_wdata),
    .s_idx(idx_of(bus_addr_i)), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
    .s_we(s_we), .s_new(s_new)
  );

  scc_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)) snoop_i (
    .clk(clk), .rst_n(rst_n),
    .cmd(snp_cmd), .req_id(bus_id_i), .req_tag(tag_of(bus_addr_i)),
    .ln_st(s_st), .ln_tag(s_tag), .ln_data(s_data),
    .hit(snp_hit), .upd_we(s_we), .upd_st(s_new),
    .abort(snp_abort), .sup_data(snp_data)
  );

  scc_ctrl_fsm fsm_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .hit(cpu_hit), .victim_dirty(victim_dirty),
    .bus_gnt(bus_gnt), .snp_busy(snp_hit),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .cmd_o(cmd_int),
    .drive_victim(drive_victim), .fill_we(fill_we), .fill_st(fill_st), .hit_we(hit_we)
  );

  assign cpu_rdata  = a_data;
  assign bus_cmd_o  = cmd_int;
  assign bus_id_o   = MY_ID;
  assign bus_addr_o = drive_victim ? {a_tag, idx_of(cpu_addr)} : cpu_addr;
  assign bus_data_o = a_data;

  // R11
  snoop_beats_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |-> !cpu_ready);

  // R6
  abort_supplies_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> (snp_cmd == BC_RDMISS || snp_cmd == BC_WRMISS));
endmodule

// File: tb/snoop_cache_ctrl_tb.sv
module snoop_cache_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int IW = 2;
  localparam int DW = 8;
  localparam int NL = 1 << IW;
  localparam int NA = 1 << AW;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req  [2];
  logic          we   [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd   [2];
  logic          rdy  [2];
  logic [DW-1:0] rd   [2];
  logic          breq [2];
  logic          gnt  [2];
  logic [1:0]    cmdo [2];
  logic [0:0]    ido  [2];
  logic [AW-1:0] ado  [2];
  logic [DW-1:0] dto  [2];
  logic          ab   [2];
  logic [DW-1:0] sd   [2];

  logic [1:0]    b_cmd;
  logic [0:0]    b_id;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_data, b_fill;
  logic          ab_any;
  logic [DW-1:0] mem [NA];
  logic          own_v;
  logic          owner;

  snoop_cache_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .ID_W(1), .MY_ID(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]),
    .cpu_wdata(wd[0]), .cpu_ready(rdy[0]), .cpu_rdata(rd[0]), .bus_req(breq[0]),
    .bus_gnt(gnt[0]), .bus_cmd_o(cmdo[0]), .bus_id_o(ido[0]), .bus_addr_o(ado[0]),
    .bus_data_o(dto[0]), .bus_cmd_i(b_cmd), .bus_id_i(b_id), .bus_addr_i(b_addr),
    .bus_fill_i(b_fill), .snp_abort(ab[0]), .snp_data(sd[0]));

  snoop_cache_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .ID_W(1), .MY_ID(1'b1)) peer_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]),
    .cpu_wdata(wd[1]), .cpu_ready(rdy[1]), .cpu_rdata(rd[1]), .bus_req(breq[1]),
    .bus_gnt(gnt[1]), .bus_cmd_o(cmdo[1]), .bus_id_o(ido[1]), .bus_addr_o(ado[1]),
    .bus_data_o(dto[1]), .bus_cmd_i(b_cmd), .bus_id_i(b_id), .bus_addr_i(b_addr),
    .bus_fill_i(b_fill), .snp_abort(ab[1]), .snp_data(sd[1]));

  // shared bus, arbiter and memory
  assign gnt[0] = own_v && !owner;
  assign gnt[1] = own_v && owner;
  always_comb begin
    b_cmd = 2'b00; b_id = 1'b0; b_addr = '0; b_data = '0;
    if (gnt[0]) begin b_cmd = cmdo[0]; b_id = ido[0]; b_addr = ado[0]; b_data = dto[0]; end
    else if (gnt[1]) begin b_cmd = cmdo[1]; b_id = ido[1]; b_addr = ado[1]; b_data = dto[1]; end
  end
  assign ab_any = ab[0] || ab[1];
  assign b_fill = ab[0] ? sd[0] : (ab[1] ? sd[1] : mem[b_addr]);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_v <= 1'b0; owner <= 1'b0;
      for (int i = 0; i < NA; i++) mem[i] <= DW'(i * 7 + 3);
    end else begin
      if (b_cmd == 2'b11) mem[b_addr] <= b_data;
      if (ab_any) mem[b_addr] <= b_fill;
      if (!own_v || !breq[owner]) begin
        if (breq[0]) begin own_v <= 1'b1; owner <= 1'b0; end
        else if (breq[1]) begin own_v <= 1'b1; owner <= 1'b1; end
        else own_v <= 1'b0;
      end
    end
  end

  // bus monitor, sampled mid-cycle
  int tot_tx = 0, tot_ab = 0;
  logic [1:0]    last_cmd = 2'b00, prev_cmd = 2'b00;
  logic [AW-1:0] wb_addr = '0;
  logic [DW-1:0] wb_data = '0;
  always @(negedge clk) begin
    if (rst_n && b_cmd != 2'b00) begin
      tot_tx++;
      prev_cmd = last_cmd;
      last_cmd = b_cmd;
      if (b_cmd == 2'b11) begin wb_addr = b_addr; wb_data = b_data; end
    end
    if (rst_n && ab_any) tot_ab++;
  end

  // reference model
  int checks = 0, errors = 0;
  int mst [2][NL];
  int mtg [2][NL];
  logic [DW-1:0] gold [NA];
  bit snp_inv [2][NL];
  bit snp_dn  [2][NL];
  bit first_op [2];

  task automatic chk(bit ok, string rq, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_op(int c, bit w, int a, int d);
    int o = 1 - c;
    int ix = a % NL;
    int tg = a / NL;
    bit hit = (mst[c][ix] != 0) && (mtg[c][ix] == tg) && (!w || mst[c][ix] == 2);
    bit vdirty = (mst[c][ix] == 2) && (mtg[c][ix] != tg);
    bit omatch = (mst[o][ix] != 0) && (mtg[o][ix] == tg);
    int exp_tx = hit ? 0 : (vdirty ? 2 : 1);
    int exp_ab = (!hit && omatch && mst[o][ix] == 2) ? 1 : 0;
    int vaddr = mtg[c][ix] * NL + ix;
    string rq;
    int tx0, ab0, waited;
    logic [DW-1:0] got;
    if (hit) rq = "R4";
    else if (snp_inv[c][ix]) rq = "R7";
    else if (snp_dn[c][ix]) rq = "R6";
    else if (vdirty) rq = "R5";
    else if (mst[c][ix] != 0) rq = "R9";
    else if (first_op[c]) rq = "R1";
    else rq = w ? "R3" : "R2";
    @(posedge clk); #1;
    tx0 = tot_tx; ab0 = tot_ab;
    req[c] = 1'b1; we[c] = w; addr[c] = AW'(a); wd[c] = DW'(d);
    waited = 0;
    got = '0;
    forever begin
      @(negedge clk);
      if (rdy[c]) begin got = rd[c]; break; end
      waited++;
      if (waited > 60) break;
    end
    chk(waited <= 60, "R11", waited, 60, "request never completed");
    chk(tot_tx - tx0 == exp_tx, rq, tot_tx - tx0, exp_tx, "bus transaction count");
    if (!hit) begin
      chk(waited >= 3, "R11", waited, 3, "ready before miss finished");
      chk(last_cmd == (w ? 2'b10 : 2'b01), w ? "R3" : "R2", last_cmd, w ? 2 : 1, "miss command");
    end
    if (vdirty) begin
      chk(prev_cmd == 2'b11, "R5", prev_cmd, 3, "write-back command");
      chk(wb_addr == AW'(vaddr), "R5", wb_addr, vaddr, "write-back address");
      chk(wb_data == gold[vaddr], "R5", wb_data, gold[vaddr], "write-back data");
    end
    chk(tot_ab - ab0 == exp_ab, exp_ab ? (w ? "R8" : "R6") : "R10", tot_ab - ab0, exp_ab, "abort count");
    if (!w) chk(got == gold[a], rq, got, gold[a], "read data");
    @(posedge clk); #1;
    req[c] = 1'b0;
    // model update
    if (!hit) begin
      if (omatch) begin
        if (w) begin mst[o][ix] = 0; snp_inv[o][ix] = 1; snp_dn[o][ix] = 0; end
        else if (mst[o][ix] == 2) begin mst[o][ix] = 1; snp_dn[o][ix] = 1; end
      end
      mst[c][ix] = w ? 2 : 1;
      mtg[c][ix] = tg;
      snp_inv[c][ix] = 0; snp_dn[c][ix] = 0;
    end
    if (w) gold[a] = DW'(d);
    first_op[c] = 0;
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      req[c] = 1'b0; we[c] = 1'b0; addr[c] = '0; wd[c] = '0; first_op[c] = 1;
      for (int i = 0; i < NL; i++) begin
        mst[c][i] = 0; mtg[c][i] = 0; snp_inv[c][i] = 0; snp_dn[c][i] = 0;
      end
    end
    for (int i = 0; i < NA; i++) gold[i] = DW'(i * 7 + 3);
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset, no request on either side
    chk(!breq[0] && !breq[1], "R1", breq[0], 0, "bus request after reset");
    chk(!rdy[0] && !rdy[1], "R1", rdy[0], 0, "ready after reset");
    // directed walk: A1 = 1, A2 = 5 share index 1
    do_op(0, 1, 1, 10);   // write miss, Exclusive
    do_op(0, 0, 1, 0);    // read hit
    do_op(0, 1, 1, 11);   // R10: own write miss not self-snooped, now a hit
    do_op(1, 0, 1, 0);    // remote read: abort, supply, downgrade (R6)
    do_op(0, 1, 1, 12);   // write to Shared needs bus (R6), invalidates peer (R7)
    do_op(1, 0, 1, 0);    // peer was invalidated: miss
    do_op(1, 1, 1, 20);   // write to Shared: write miss
    do_op(1, 1, 5, 40);   // conflicting address: write-back then miss (R5, R9)
    do_op(0, 0, 1, 0);    // reads 20 from memory
    do_op(1, 0, 1, 0);    // R9: tag differs from Exclusive line, victim written back
    for (int n = 0; n < 400; n++) begin
      do_op(int'($urandom_range(1, 0)), bit'($urandom_range(1, 0)),
            int'($urandom_range(NA - 1, 0)), int'($urandom_range(255, 0)));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule